// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block is a small translation cache that turns a virtual page number into a physical page number. It has 32 entries in 8 sets of 4 ways. The lookup side is purely combinational. A virtual address presented on the lookup port returns hit, the physical address and the page permission bits in the same cycle, so it adds no cycles to a memory access. A single buffer serves both instruction fetch and data accesses. The requester multiplexes its address onto the one lookup port.

A page walker outside this block installs a translation through the fill port once a walk completes. It sends the virtual page number, the physical page number, a writable bit and a user bit. A flush input drops every translation at once, for example after the page tables are switched.

Pages are 4 KB. Address bits [14:12] choose the set, and bits [31:15] are the tag held in each way. Only the four ways of one set are compared on any lookup. A fully associative design would compare all 32 entries.

Top module: `xlat_cache`

## Requirements
- R1: After reset, and while `rst_ni` is low, every lookup misses. On a miss, `lk_paddr_o`, `lk_wr_o` and `lk_usr_o` are all zero.
- R2: A lookup resolves in the same cycle it is presented. A translation filled at a clock edge hits from the cycle that follows that edge. A lookup in the same cycle as the fill of that page still misses.
- R3: On a hit, `lk_paddr_o` is the stored 20-bit physical page number concatenated with `lk_vaddr_i[11:0]`. `lk_wr_o` and `lk_usr_o` carry the stored writable and user bits.
- R4: The set index is `lk_vaddr_i[14:12]` (`fill_vpn_i[2:0]`) and the tag is `lk_vaddr_i[31:15]` (`fill_vpn_i[19:3]`). Pages that differ only in the index land in separate sets and do not disturb each other.
- R5: Asserting `flush_i` for one cycle invalidates every entry at that clock edge. Lookups in later cycles miss until the page is filled again.
- R6: A lookup in a cycle where `flush_i` is high reports a miss, even if the page was resident.
- R7: A fill whose tag is not already in its set writes the lowest-numbered invalid way of that set.
- R8: When the set has no invalid way, the fill replaces the way named by a 2-bit per-set pointer. The pointer is 0 after reset and advances by one, modulo 4, on every accepted fill to that set. A flush does not change it.
- R9: A fill whose tag is already valid in its set overwrites that way. Exactly one copy remains, and it carries the new page number and permissions.
- R10: When `fill_en_i` and `flush_i` are high in the same cycle, the flush takes effect and the fill is discarded. The discarded fill does not advance the pointer.
- R11: The buffer holds 32 translations at once, four per set. After 32 fills spread four to each set, all 32 pages hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries |
| lk_vaddr_i | input | 32 | Lookup virtual address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_paddr_o | output | 32 | Translated physical address (zero on miss) |
| lk_wr_o | output | 1 | Page writable (zero on miss) |
| lk_usr_o | output | 1 | Page user-accessible (zero on miss) |
| fill_en_i | input | 1 | Install a translation this cycle |
| fill_vpn_i | input | 20 | Virtual page number to install |
| fill_ppn_i | input | 20 | Physical page number to install |
| fill_wr_i | input | 1 | Writable bit to install |
| fill_usr_i | input | 1 | User bit to install |

## Verification
Every lookup reads state directly, so a wrong valid bit, tag or page number shows at the ports in the first cycle its page is looked up. A wrong replacement pointer or a wrong free-way choice stays hidden until the set is full. It then appears when the wrong resident page goes missing, one fill after the faulty eviction. The bench keeps a small tag pool so that sets overflow often. It also looks up pages at random and compares hit, address and permissions every cycle, so a divergence in hidden state is reported within a few cycles of the first lookup that touches it.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int XL_VA_W   = 32;
  localparam int XL_PAGE_W = 12;
  localparam int XL_PPN_W  = 20;
  localparam int XL_SETS   = 8;
  localparam int XL_WAYS   = 4;

  localparam int XL_IDX_W  = $clog2(XL_SETS);
  localparam int XL_WAY_W  = $clog2(XL_WAYS);
  localparam int XL_VPN_W  = XL_VA_W - XL_PAGE_W;
  localparam int XL_TAG_W  = XL_VPN_W - XL_IDX_W;

  typedef struct packed {
    logic                vld;
    logic [XL_TAG_W-1:0] tag;
    logic [XL_PPN_W-1:0] ppn;
    logic                wr;
    logic                usr;
  } xl_entry_t;

  typedef xl_entry_t [XL_WAYS-1:0] xl_set_t;
endpackage

// File: rtl/xlat_set_store.sv
module xlat_set_store
  import xlat_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic                wr_en_i,
  input  logic [XL_TAG_W-1:0] wr_tag_i,
  input  logic [XL_PPN_W-1:0] wr_ppn_i,
  input  logic                wr_w_i,
  input  logic                wr_u_i,
  output xl_set_t             ent_o
);
  xl_set_t             ent_q;
  logic [XL_WAY_W-1:0] rr_q;
  logic [XL_WAY_W-1:0] dup_way, free_way, victim;
  logic                dup_any, free_any;

  // priority: existing tag, then lowest free way, then round-robin
  always_comb begin
    dup_any  = 1'b0;
    free_any = 1'b0;
    dup_way  = '0;
    free_way = '0;
    for (int w = XL_WAYS - 1; w >= 0; w--) begin
      if (ent_q[w].vld && ent_q[w].tag == wr_tag_i) begin
        dup_any = 1'b1;
        dup_way = w[XL_WAY_W-1:0];
      end
      if (!ent_q[w].vld) begin
        free_any = 1'b1;
        free_way = w[XL_WAY_W-1:0];
      end
    end
    victim = dup_any ? dup_way : (free_any ? free_way : rr_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q <= '0;
      rr_q  <= '0;
    end else if (flush_i) begin
      for (int w = 0; w < XL_WAYS; w++) ent_q[w].vld <= 1'b0;
    end else if (wr_en_i) begin
      ent_q[victim].vld <= 1'b1;
      ent_q[victim].tag <= wr_tag_i;
      ent_q[victim].ppn <= wr_ppn_i;
      ent_q[victim].wr  <= wr_w_i;
      ent_q[victim].usr <= wr_u_i;
      rr_q              <= rr_q + 1'b1;
    end
  end

  assign ent_o = ent_q;
endmodule

// File: rtl/xlat_match.sv
module xlat_match
  import xlat_pkg::*;
(
  input  xl_set_t             set_i,
  input  logic [XL_TAG_W-1:0] tag_i,
  input  logic                kill_i,
  output logic [XL_WAYS-1:0]  hit_vec_o,
  output logic                hit_o,
  output xl_entry_t           ent_o
);
  always_comb begin
    hit_vec_o = '0;
    ent_o     = '0;
    for (int w = 0; w < XL_WAYS; w++) begin
      hit_vec_o[w] = set_i[w].vld && (set_i[w].tag == tag_i) && !kill_i;
      if (hit_vec_o[w]) ent_o = xl_entry_t'(ent_o | set_i[w]);
    end
  end

  assign hit_o = |hit_vec_o;
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic [XL_VA_W-1:0]  lk_vaddr_i,
  output logic                lk_hit_o,
  output logic [XL_VA_W-1:0]  lk_paddr_o,
  output logic                lk_wr_o,
  output logic                lk_usr_o,
  input  logic                fill_en_i,
  input  logic [XL_VPN_W-1:0] fill_vpn_i,
  input  logic [XL_PPN_W-1:0] fill_ppn_i,
  input  logic                fill_wr_i,
  input  logic                fill_usr_i
);
  logic [XL_IDX_W-1:0] lk_idx, fill_idx;
  logic [XL_TAG_W-1:0] lk_tag, fill_tag;
  xl_set_t             sets [XL_SETS];
  xl_set_t             set_sel;
  xl_entry_t           ent_sel;
  logic [XL_WAYS-1:0]  hit_vec;
  logic                hit;

  assign lk_idx   = lk_vaddr_i[XL_PAGE_W +: XL_IDX_W];
  assign lk_tag   = lk_vaddr_i[XL_VA_W-1 -: XL_TAG_W];
  assign fill_idx = fill_vpn_i[XL_IDX_W-1:0];
  assign fill_tag = fill_vpn_i[XL_VPN_W-1 -: XL_TAG_W];

  for (genvar s = 0; s < XL_SETS; s++) begin : g_set
    localparam logic [XL_IDX_W-1:0] SIDX = s;
    xlat_set_store u_store (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (flush_i),
      .wr_en_i (fill_en_i && (fill_idx == SIDX)),
      .wr_tag_i(fill_tag),
      .wr_ppn_i(fill_ppn_i),
      .wr_w_i  (fill_wr_i),
      .wr_u_i  (fill_usr_i),
      .ent_o   (sets[s])
    );
  end

  assign set_sel = sets[lk_idx];

  xlat_match u_match (
    .set_i    (set_sel),
    .tag_i    (lk_tag),
    .kill_i   (flush_i),
    .hit_vec_o(hit_vec),
    .hit_o    (hit),
    .ent_o    (ent_sel)
  );

  assign lk_hit_o   = hit;
  assign lk_paddr_o = hit ? {ent_sel.ppn, lk_vaddr_i[XL_PAGE_W-1:0]} : '0;
  assign lk_wr_o    = hit & ent_sel.wr;
  assign lk_usr_o   = hit & ent_sel.usr;
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
  import xlat_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                flush_i,
  input logic [XL_VA_W-1:0]  lk_vaddr_i,
  input logic                lk_hit_o,
  input logic [XL_VA_W-1:0]  lk_paddr_o,
  input logic                lk_wr_o,
  input logic                lk_usr_o,
  input logic                fill_en_i,
  input logic [XL_VPN_W-1:0] fill_vpn_i,
  input logic [XL_PPN_W-1:0] fill_ppn_i,
  input logic [XL_WAYS-1:0]  hit_vec
);
  p_flush_miss_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !lk_hit_o);

  p_flushed_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !lk_hit_o);

  p_miss_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_paddr_o == '0 && !lk_wr_o && !lk_usr_o));

  p_offset_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_paddr_o[XL_PAGE_W-1:0] == lk_vaddr_i[XL_PAGE_W-1:0]);

  p_fill_visible_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en_i && !flush_i) |=>
      (lk_vaddr_i[XL_VA_W-1:XL_PAGE_W] != $past(fill_vpn_i) || flush_i ||
       (lk_hit_o && lk_paddr_o[XL_VA_W-1:XL_PAGE_W] == $past(fill_ppn_i))));

  p_single_copy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
endmodule

bind xlat_cache xlat_cache_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .flush_i   (flush_i),
  .lk_vaddr_i(lk_vaddr_i),
  .lk_hit_o  (lk_hit_o),
  .lk_paddr_o(lk_paddr_o),
  .lk_wr_o   (lk_wr_o),
  .lk_usr_o  (lk_usr_o),
  .fill_en_i (fill_en_i),
  .fill_vpn_i(fill_vpn_i),
  .fill_ppn_i(fill_ppn_i),
  .hit_vec   (hit_vec)
);

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [31:0] lk_va = '0;
  logic        hit_o, wr_o, usr_o;
  logic [31:0] pa_o;
  logic        f_en = 1'b0;
  logic [19:0] f_vpn = '0;
  logic [19:0] f_ppn = '0;
  logic        f_w = 1'b0;
  logic        f_u = 1'b0;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference state
  bit m_vld [8][4];
  int m_tag [8][4];
  int m_ppn [8][4];
  bit m_wr  [8][4];
  bit m_us  [8][4];
  int m_ptr [8];

  always #(CLK_P/2) clk = ~clk;

  xlat_cache u_xlat_cache (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .lk_vaddr_i(lk_va), .lk_hit_o(hit_o), .lk_paddr_o(pa_o),
    .lk_wr_o(wr_o), .lk_usr_o(usr_o),
    .fill_en_i(f_en), .fill_vpn_i(f_vpn), .fill_ppn_i(f_ppn),
    .fill_wr_i(f_w), .fill_usr_i(f_u)
  );

  function automatic logic [31:0] mk_va(int tag, int idx, int off);
    return {tag[16:0], idx[2:0], off[11:0]};
  endfunction

  task automatic model_clear();
    for (int s = 0; s < 8; s++) begin
      m_ptr[s] = 0;
      for (int w = 0; w < 4; w++) m_vld[s][w] = 0;
    end
  endtask

  task automatic tick(input string req);
    bit e_hit, e_w, e_u;
    logic [31:0] e_pa;
    int s, t, v;
    #1;
    e_hit = 0; e_w = 0; e_u = 0; e_pa = '0;
    s = int'(lk_va[14:12]);
    t = int'(lk_va[31:15]);
    if (rst_n && !flush)
      for (int w = 0; w < 4; w++)
        if (m_vld[s][w] && m_tag[s][w] == t) begin
          e_hit = 1; e_w = m_wr[s][w]; e_u = m_us[s][w];
          e_pa = {m_ppn[s][w][19:0], lk_va[11:0]};
        end
    compared++;
    if (hit_o !== e_hit || pa_o !== e_pa || wr_o !== e_w || usr_o !== e_u) begin
      mismatched++;
      $display("FAIL %s: va=%h got hit=%b pa=%h wr=%b usr=%b exp hit=%b pa=%h wr=%b usr=%b",
               req, lk_va, hit_o, pa_o, wr_o, usr_o, e_hit, e_pa, e_w, e_u);
    end
    // state update at the coming edge
    if (!rst_n) model_clear();
    else if (flush) begin
      for (int a = 0; a < 8; a++) for (int w = 0; w < 4; w++) m_vld[a][w] = 0;
    end else if (f_en) begin
      s = int'(f_vpn[2:0]);
      t = int'(f_vpn[19:3]);
      v = -1;
      for (int w = 0; w < 4; w++) if (v < 0 && m_vld[s][w] && m_tag[s][w] == t) v = w;
      for (int w = 0; w < 4; w++) if (v < 0 && !m_vld[s][w]) v = w;
      if (v < 0) v = m_ptr[s];
      m_vld[s][v] = 1; m_tag[s][v] = t; m_ppn[s][v] = int'(f_ppn);
      m_wr[s][v] = f_w; m_us[s][v] = f_u;
      m_ptr[s] = (m_ptr[s] + 1) % 4;
    end
    @(negedge clk);
  endtask

  task automatic look(input logic [31:0] va, input string req);
    lk_va = va; f_en = 0; flush = 0;
    tick(req);
  endtask

  task automatic fill(input int tag, input int idx, input int ppn, input bit w, input bit u,
                      input string req);
    f_en = 1; f_vpn = {tag[16:0], idx[2:0]}; f_ppn = ppn[19:0]; f_w = w; f_u = u; flush = 0;
    tick(req);
    f_en = 0;
  endtask

  initial begin
    model_clear();
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) look(mk_va(i, i, 16 * i), "R1");
    rst_n = 1'b1;
    look(mk_va(0, 0, 0), "R1");
    // R2: same-cycle fill misses, next cycle hits
    lk_va = mk_va(9, 5, 'habc);
    fill(9, 5, 'hABCDE, 1, 0, "R2");
    look(mk_va(9, 5, 'habc), "R2");
    // R3: offset and permission bits
    fill(11, 2, 'h13579, 0, 1, "R3");
    look(mk_va(11, 2, 'h7ff), "R3");
    look(mk_va(11, 2, 'h001), "R3");
    // R4: index vs tag separation
    look(mk_va(9, 4, 'habc), "R4");
    look(mk_va(8, 5, 'habc), "R4");
    fill(9, 4, 'h22222, 1, 1, "R4");
    look(mk_va(9, 4, 'h010), "R4");
    look(mk_va(9, 5, 'h010), "R4");
    // R7/R8: fill five tags into set 3; fifth evicts way 0
    for (int k = 0; k < 5; k++) fill(100 + k, 3, 'h30000 + k, k[0], k[1], "R7");
    for (int k = 0; k < 5; k++) look(mk_va(100 + k, 3, 'h444), "R8");
    fill(200, 3, 'h3ffff, 1, 1, "R8");
    for (int k = 0; k < 5; k++) look(mk_va(100 + k, 3, 'h444), "R8");
    look(mk_va(200, 3, 'h444), "R8");
    // R9: refill resident tag
    fill(103, 3, 'h0beef, 0, 0, "R9");
    look(mk_va(103, 3, 'h123), "R9");
    look(mk_va(104, 3, 'h123), "R9");
    // R6: lookup during flush
    lk_va = mk_va(103, 3, 'h5); flush = 1;
    tick("R6");
    flush = 0;
    // R5: everything gone after flush
    look(mk_va(103, 3, 'h5), "R5");
    look(mk_va(9, 5, 'habc), "R5");
    // R10: fill with flush in same cycle is dropped
    f_en = 1; f_vpn = {17'd77, 3'd6}; f_ppn = 20'h77777; flush = 1; lk_va = '0;
    tick("R10");
    f_en = 0; flush = 0;
    look(mk_va(77, 6, 0), "R10");
    // R8: pointer kept across flush (set 3 pointer now at 3)
    for (int k = 0; k < 5; k++) fill(300 + k, 3, 'h40000 + k, 0, 0, "R8");
    for (int k = 0; k < 5; k++) look(mk_va(300 + k, 3, 0), "R8");
    // R11: full capacity
    flush = 1; tick("R5"); flush = 0;
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 4; k++) fill(500 + k, s, s * 16 + k, 1, 0, "R11");
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 4; k++) look(mk_va(500 + k, s, 'h0f0), "R11");
    // randomized traffic with a small tag pool
    for (int i = 0; i < 4000; i++) begin
      lk_va = mk_va($urandom_range(0, 6), $urandom_range(0, 7), $urandom_range(0, 4095));
      f_en  = ($urandom_range(0, 2) == 0);
      f_vpn = {17'($urandom_range(0, 6)), 3'($urandom_range(0, 7))};
      f_ppn = 20'($urandom);
      f_w   = 1'($urandom);
      f_u   = 1'($urandom);
      flush = ($urandom_range(0, 63) == 0);
      tick("R2 R8 R9 random");
    end
    f_en = 0; flush = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got no completion, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule